// File: doc/BRIEF.md
# Data Reference Fault Status Register

This block watches the data memory references of a processor pipeline and keeps a record of the most recent data access fault so that a trap handler can read it. Every cycle it receives one reference with its attributes: the address-space identifier and how it decodes, the current and ASI-named contexts, the privilege mode, the operation class, and the attributes of the matching translation entry. A combinational classifier turns these into a 7-bit fault-type vector. One bit stands for each cause, and several bits can be set together. A small state machine keeps the sticky valid and overrun flags. A field register holds the context, privilege, write and fault-type values.

The state machine has three states. ST_EMPTY means no fault is held. ST_HELD means one fault is held. ST_OVERRUN means a further fault arrived while one was already held. A detected fault moves ST_EMPTY to ST_HELD (transition T_CAPTURE), and moves ST_HELD or ST_OVERRUN to ST_OVERRUN (T_OVERRUN). A software write with no fault in the same cycle goes to ST_EMPTY if it writes bit 0 as 0 (T_CLEAR). Otherwise it goes to ST_OVERRUN if bit 1 is written as 1, or to ST_HELD if it is not (T_LOAD). In every other cycle the state is held (T_STAY).

Software reads the whole register on `rd_data` and writes it with `sw_we`/`sw_wdata`. Register layout: bit 0 valid, bit 1 overrun, bit 2 write, bit 3 privilege, bits 5:4 context type, bits 14:8 fault type. All other bits read 0.

Top module: `fsr_capture`

## Requirements
- R1: After reset, `rd_data` reads 0x0000 and the state machine is in ST_EMPTY.
- R2: Fault-type bit 0 (register bit 8), privilege violation, is set when the reference is translating (ASI neither nontranslating nor invalid), the entry hits, its privileged attribute is 1, and either `ref_priv` is 0 or `ref_as_if_user` is 1.
- R3: Fault-type bit 3 (register bit 11), protection, is set for a write-class operation (store code 1 or atomic code 2) to a translating hit entry whose writable attribute is 0. It is not set when fault-type bit 0 is set for the same reference.
- R4: Fault-type bit 1 (register bit 9) is set for a nonfaulting load (`ref_nf_load` with load code 0) to a translating hit entry with the side-effect attribute. It is never set for a nontranslating ASI.
- R5: Fault-type bit 2 (register bit 10) is set for an atomic operation (code 2), or for a quad load (code 3 with ASI equal to 0x24, 0x2C, 0x34 or 0x3C), when the target is a translating hit page that is not cacheable or when the ASI is nontranslating.
- R6: Fault-type bit 4 (register bit 12) is set by `ref_bad_combo`, and bit 5 (register bit 13) by `ref_asi_invalid`. Every cause sets its own bit independently, and bit 6 always reads 0.
- R7: The context-type field (bits 5:4) is 11 for a nontranslating or invalid ASI. Otherwise it is `ref_asi_ctx` when `ref_use_asi` or `ref_bad_combo` is 1, and `ref_cur_ctx` in all other cases (00 primary, 01 secondary, 10 nucleus).
- R8: The valid bit (bit 0) becomes 1 in the cycle after any valid reference with a nonzero fault type. A translating miss with no fault leaves it unchanged. Such a miss loads only the context-type field, and only while valid is 0. A reference with `ref_valid` at 0 changes nothing.
- R9: A fault that arrives while valid is 1 sets the overrun bit (bit 1). The write, privilege, context and fault-type fields then take the newer fault's values.
- R10: On capture, the write bit (bit 2) is 1 for store or atomic codes, and the privilege bit (bit 3) equals `ref_priv`.
- R11: A software write loads all defined fields from `sw_wdata`. Writing bit 0 as 0 clears both valid and overrun. A fault capture in the same cycle takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A data reference is presented this cycle |
| ref_asi | input | 8 | Address-space identifier of the reference |
| ref_op | input | 2 | 0 load, 1 store, 2 atomic, 3 load with ASI (quad candidate) |
| ref_nf_load | input | 1 | Load is nonfaulting |
| ref_priv | input | 1 | Processor is privileged |
| ref_as_if_user | input | 1 | ASI requests user-mode checking |
| ref_use_asi | input | 1 | Instruction carries an explicit ASI |
| ref_cur_ctx | input | 2 | Context type for implicit references |
| ref_asi_ctx | input | 2 | Context type named by the ASI |
| ref_asi_nontrans | input | 1 | ASI is nontranslating (internal) |
| ref_asi_invalid | input | 1 | ASI is invalid |
| ref_bad_combo | input | 1 | Illegal ASI and opcode pairing |
| tte_hit | input | 1 | Translation entry matched |
| tte_priv | input | 1 | Entry privileged attribute |
| tte_side_eff | input | 1 | Entry side-effect attribute |
| tte_cacheable | input | 1 | Entry cacheable attribute |
| tte_writable | input | 1 | Entry writable attribute |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 16 | Software write data |
| rd_data | output | 16 | Register read value |

## Verification
The bench sweeps 8192 reference patterns, each after a clear. The patterns cover every mix of privilege, entry attributes, operation code, quad-ASI match and ASI kind. A classifier that let a privilege violation coexist with a protection fault, or that flagged side-effect loads through internal ASIs, would show a wrong fault-type field here. Directed sequences then go after the sticky behaviour. A second fault must set overrun and replace the fields, and a capture that lost to a simultaneous clearing write would read back as empty. A miss that arrives while a fault is held must not corrupt the context type, and a reference with `ref_valid` at 0 must leave the register untouched.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int FT_W   = 7;
    localparam int REG_W  = 16;
    localparam int BIT_FV = 0;
    localparam int BIT_OW = 1;
    localparam int BIT_WR = 2;
    localparam int BIT_PR = 3;
    localparam int CT_LSB = 4;
    localparam int FT_LSB = 8;

    localparam int FTB_PRIV  = 0;
    localparam int FTB_SIDE  = 1;
    localparam int FTB_ATOM  = 2;
    localparam int FTB_PROT  = 3;
    localparam int FTB_COMBO = 4;
    localparam int FTB_BADASI = 5;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_ATOMIC = 2'd2,
        OP_LDA    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_HELD    = 2'd1,
        ST_OVERRUN = 2'd2
    } hold_e;

    typedef struct packed {
        logic [1:0]      ct;
        logic            pr;
        logic            wr;
        logic [FT_W-1:0] ft;
    } fault_rec_t;
endpackage

// File: rtl/fsr_classify.sv
module fsr_classify
    import fsr_pkg::*;
#(
    parameter int          ASI_W     = 8,
    parameter logic [7:0]  QUAD_BASE = 8'h24,
    parameter logic [7:0]  QUAD_MASK = 8'hE7
) (
    input  logic             ref_valid,
    input  logic [ASI_W-1:0] ref_asi,
    input  logic [1:0]       ref_op,
    input  logic             ref_nf_load,
    input  logic             ref_priv,
    input  logic             ref_as_if_user,
    input  logic             ref_use_asi,
    input  logic [1:0]       ref_cur_ctx,
    input  logic [1:0]       ref_asi_ctx,
    input  logic             ref_asi_nontrans,
    input  logic             ref_asi_invalid,
    input  logic             ref_bad_combo,
    input  logic             tte_hit,
    input  logic             tte_priv,
    input  logic             tte_side_eff,
    input  logic             tte_cacheable,
    input  logic             tte_writable,
    output fault_rec_t       rec,
    output logic             fault,
    output logic             miss
);
    localparam logic [ASI_W-1:0] QB = ASI_W'(QUAD_BASE);
    localparam logic [ASI_W-1:0] QM = ASI_W'(QUAD_MASK);

    op_e        op;
    logic       translating;
    logic       hit_tr;
    logic       is_write;
    logic       quad_ld;
    logic       atomic_cls;
    logic [FT_W-1:0] ft;

    always_comb begin
        op          = op_e'(ref_op);
        translating = !ref_asi_nontrans && !ref_asi_invalid;
        hit_tr      = translating && tte_hit;
        is_write    = (op == OP_STORE) || (op == OP_ATOMIC);
        quad_ld     = (op == OP_LDA) && ((ref_asi & QM) == QB);
        atomic_cls  = (op == OP_ATOMIC) || quad_ld;

        ft = '0;
        ft[FTB_PRIV]   = hit_tr && tte_priv && (!ref_priv || ref_as_if_user);
        ft[FTB_PROT]   = hit_tr && is_write && !tte_writable && !ft[FTB_PRIV];
        ft[FTB_SIDE]   = hit_tr && ref_nf_load && (op == OP_LOAD) && tte_side_eff;
        ft[FTB_ATOM]   = atomic_cls && ((hit_tr && !tte_cacheable) || ref_asi_nontrans);
        ft[FTB_COMBO]  = ref_bad_combo;
        ft[FTB_BADASI] = ref_asi_invalid;
        if (!ref_valid) ft = '0;

        rec.ft = ft;
        rec.wr = is_write;
        rec.pr = ref_priv;
        if (!translating)
            rec.ct = 2'b11;
        else if (ref_use_asi || ref_bad_combo)
            rec.ct = ref_asi_ctx;
        else
            rec.ct = ref_cur_ctx;

        fault = |ft;
        miss  = ref_valid && translating && !tte_hit && !fault;
    end
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic sw_we,
    input  logic sw_fv,
    input  logic sw_ow,
    output logic fv,
    output logic ow
);
    hold_e state_q;
    hold_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (fault)                state_d = ST_HELD;
                else if (sw_we && sw_fv)  state_d = sw_ow ? ST_OVERRUN : ST_HELD;
            end
            ST_HELD: begin
                if (fault)                state_d = ST_OVERRUN;
                else if (sw_we && !sw_fv) state_d = ST_EMPTY;
                else if (sw_we)           state_d = sw_ow ? ST_OVERRUN : ST_HELD;
            end
            ST_OVERRUN: begin
                if (fault)                state_d = ST_OVERRUN;
                else if (sw_we && !sw_fv) state_d = ST_EMPTY;
                else if (sw_we)           state_d = sw_ow ? ST_OVERRUN : ST_HELD;
            end
            default:                      state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        fv = 1'b0;
        ow = 1'b0;
        unique case (state_q)
            ST_EMPTY:   begin fv = 1'b0; ow = 1'b0; end
            ST_HELD:    begin fv = 1'b1; ow = 1'b0; end
            ST_OVERRUN: begin fv = 1'b1; ow = 1'b1; end
            default:    begin fv = 1'b0; ow = 1'b0; end
        endcase
    end
endmodule

// File: rtl/fsr_fields.sv
module fsr_fields
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault,
    input  logic       miss,
    input  logic       fv,
    input  fault_rec_t new_rec,
    input  logic       sw_we,
    input  fault_rec_t sw_rec,
    output fault_rec_t cur_rec
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_rec <= '0;
        end else if (fault) begin
            cur_rec <= new_rec;
        end else if (sw_we) begin
            cur_rec <= sw_rec;
        end else if (miss && !fv) begin
            cur_rec.ct <= new_rec.ct;
        end
    end
endmodule

// File: rtl/fsr_capture.sv
module fsr_capture
    import fsr_pkg::*;
#(
    parameter int         ASI_W     = 8,
    parameter logic [7:0] QUAD_BASE = 8'h24,
    parameter logic [7:0] QUAD_MASK = 8'hE7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic [ASI_W-1:0] ref_asi,
    input  logic [1:0]       ref_op,
    input  logic             ref_nf_load,
    input  logic             ref_priv,
    input  logic             ref_as_if_user,
    input  logic             ref_use_asi,
    input  logic [1:0]       ref_cur_ctx,
    input  logic [1:0]       ref_asi_ctx,
    input  logic             ref_asi_nontrans,
    input  logic             ref_asi_invalid,
    input  logic             ref_bad_combo,
    input  logic             tte_hit,
    input  logic             tte_priv,
    input  logic             tte_side_eff,
    input  logic             tte_cacheable,
    input  logic             tte_writable,
    input  logic             sw_we,
    input  logic [REG_W-1:0] sw_wdata,
    output logic [REG_W-1:0] rd_data
);
    fault_rec_t cls_rec;
    fault_rec_t held_rec;
    fault_rec_t sw_rec;
    logic       cls_fault;
    logic       cls_miss;
    logic       st_fv;
    logic       st_ow;

    fsr_classify #(
        .ASI_W(ASI_W), .QUAD_BASE(QUAD_BASE), .QUAD_MASK(QUAD_MASK)
    ) u_cls (
        .ref_valid(ref_valid), .ref_asi(ref_asi), .ref_op(ref_op),
        .ref_nf_load(ref_nf_load), .ref_priv(ref_priv),
        .ref_as_if_user(ref_as_if_user), .ref_use_asi(ref_use_asi),
        .ref_cur_ctx(ref_cur_ctx), .ref_asi_ctx(ref_asi_ctx),
        .ref_asi_nontrans(ref_asi_nontrans), .ref_asi_invalid(ref_asi_invalid),
        .ref_bad_combo(ref_bad_combo), .tte_hit(tte_hit), .tte_priv(tte_priv),
        .tte_side_eff(tte_side_eff), .tte_cacheable(tte_cacheable),
        .tte_writable(tte_writable),
        .rec(cls_rec), .fault(cls_fault), .miss(cls_miss)
    );

    fsr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .fault(cls_fault), .sw_we(sw_we),
        .sw_fv(sw_wdata[BIT_FV]), .sw_ow(sw_wdata[BIT_OW]),
        .fv(st_fv), .ow(st_ow)
    );

    always_comb begin
        sw_rec.ct = sw_wdata[CT_LSB +: 2];
        sw_rec.pr = sw_wdata[BIT_PR];
        sw_rec.wr = sw_wdata[BIT_WR];
        sw_rec.ft = sw_wdata[FT_LSB +: FT_W];
        sw_rec.ft[FT_W-1] = 1'b0;
    end

    fsr_fields u_fld (
        .clk(clk), .rst_n(rst_n), .fault(cls_fault), .miss(cls_miss),
        .fv(st_fv), .new_rec(cls_rec), .sw_we(sw_we), .sw_rec(sw_rec),
        .cur_rec(held_rec)
    );

    always_comb begin
        rd_data = '0;
        rd_data[BIT_FV]          = st_fv;
        rd_data[BIT_OW]          = st_ow;
        rd_data[BIT_WR]          = held_rec.wr;
        rd_data[BIT_PR]          = held_rec.pr;
        rd_data[CT_LSB +: 2]     = held_rec.ct;
        rd_data[FT_LSB +: FT_W]  = held_rec.ft;
    end
endmodule

// File: rtl/fsr_capture_chk.sv
module fsr_capture_chk
    import fsr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             fault,
    input logic             miss,
    input logic [FT_W-1:0]  ft,
    input logic             sw_we,
    input logic [REG_W-1:0] sw_wdata,
    input logic [REG_W-1:0] rd_data
);
    a_r8_fault_sets_fv: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> rd_data[BIT_FV]);

    a_r9_second_sets_ow: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && rd_data[BIT_FV]) |=> rd_data[BIT_OW]);

    a_r9_ft_newest: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> rd_data[FT_LSB +: FT_W] == $past(ft));

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !sw_wdata[BIT_FV] && !fault) |=> rd_data[1:0] == 2'b00);

    a_r8_miss_keeps_fv: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !sw_we) |=> rd_data[BIT_FV] == $past(rd_data[BIT_FV]));

    a_r3_prot_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ft[FTB_PRIV] |-> !ft[FTB_PROT]);

    a_r9_ow_needs_fv: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_OW] |-> rd_data[BIT_FV]);

    a_r6_top_ft_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[FT_LSB + FT_W - 1]);
endmodule

bind fsr_capture fsr_capture_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fault(cls_fault), .miss(cls_miss),
    .ft(cls_rec.ft), .sw_we(sw_we), .sw_wdata(sw_wdata), .rd_data(rd_data)
);

// File: tb/sim_fsr_capture.sv
`timescale 1ns/1ps
module sim_fsr_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_valid = 0;
    logic [7:0]  ref_asi = 0;
    logic [1:0]  ref_op = 0;
    logic        ref_nf_load = 0, ref_priv = 0, ref_as_if_user = 0, ref_use_asi = 0;
    logic [1:0]  ref_cur_ctx = 0, ref_asi_ctx = 0;
    logic        ref_asi_nontrans = 0, ref_asi_invalid = 0, ref_bad_combo = 0;
    logic        tte_hit = 0, tte_priv = 0, tte_side_eff = 0, tte_cacheable = 0, tte_writable = 0;
    logic        sw_we = 0;
    logic [15:0] sw_wdata = 0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fsr_capture u0 (.*);

    task automatic check(input string req, input logic [15:0] exp);
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    task automatic idle_ref();
        ref_valid = 0; ref_asi = 0; ref_op = 0; ref_nf_load = 0; ref_priv = 0;
        ref_as_if_user = 0; ref_use_asi = 0; ref_cur_ctx = 0; ref_asi_ctx = 0;
        ref_asi_nontrans = 0; ref_asi_invalid = 0; ref_bad_combo = 0;
        tte_hit = 0; tte_priv = 0; tte_side_eff = 0; tte_cacheable = 0; tte_writable = 0;
    endtask

    task automatic sw_write(input logic [15:0] d);
        @(negedge clk);
        sw_we = 1; sw_wdata = d;
        @(negedge clk);
        sw_we = 0; sw_wdata = 0;
    endtask

    // apply a reference for one cycle; returns at the negedge after capture
    task automatic step();
        @(negedge clk);
        idle_ref();
    endtask

    function automatic logic [15:0] model(input int i);
        logic priv, aiu, p, e, cp, w, hit, nf, quad, nt, inv, bad, tr, th, wr, atom;
        logic [1:0] op, ct, cur, named;
        logic use_asi;
        logic [6:0] ft;
        logic [15:0] r;
        priv = i[0]; aiu = i[1]; p = i[2]; e = i[3]; cp = i[4]; w = i[5];
        hit = i[6]; nf = i[7]; op = i[9:8]; quad = i[10];
        nt = (i[12:11] == 2'd1); inv = (i[12:11] == 2'd2); bad = (i[12:11] == 2'd3);
        cur = 2'(i % 3); named = 2'((i >> 4) % 3); use_asi = i[3] ^ i[5];
        tr = !nt && !inv; th = tr && hit;
        wr = (op == 2'd1) || (op == 2'd2);
        atom = (op == 2'd2) || (op == 2'd3 && quad);
        ft = '0;
        ft[0] = th && p && (!priv || aiu);
        ft[3] = th && wr && !w && !ft[0];
        ft[1] = th && nf && op == 2'd0 && e;
        ft[2] = atom && ((th && !cp) || nt);
        ft[4] = bad;
        ft[5] = inv;
        ct = !tr ? 2'b11 : ((use_asi || bad) ? named : cur);
        r = '0;
        if (ft != 0) begin
            r[0] = 1; r[2] = wr; r[3] = priv; r[5:4] = ct; r[14:8] = ft;
        end else if (tr && !hit) begin
            r[5:4] = ct;
        end
        return r;
    endfunction

    task automatic drive_sweep(input int i);
        logic [7:0] qa [4];
        qa[0] = 8'h24; qa[1] = 8'h2C; qa[2] = 8'h34; qa[3] = 8'h3C;
        ref_valid = 1;
        ref_priv = i[0]; ref_as_if_user = i[1]; tte_priv = i[2]; tte_side_eff = i[3];
        tte_cacheable = i[4]; tte_writable = i[5]; tte_hit = i[6]; ref_nf_load = i[7];
        ref_op = i[9:8];
        ref_asi = i[10] ? qa[i[1:0]] : (8'h26 ^ {i[1:0], 6'd0});
        ref_asi_nontrans = (i[12:11] == 2'd1);
        ref_asi_invalid  = (i[12:11] == 2'd2);
        ref_bad_combo    = (i[12:11] == 2'd3);
        ref_cur_ctx = 2'(i % 3); ref_asi_ctx = 2'((i >> 4) % 3); ref_use_asi = i[3] ^ i[5];
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset value", 16'h0000);

        // R2..R7, R10 sweep: clear, one reference, compare
        for (int i = 0; i < 8192; i++) begin
            sw_write(16'h0000);
            drive_sweep(i);
            step();
            check($sformatf("R2-sweep(R3 R4 R5 R6 R7 R10) i=%0d", i), model(i));
        end

        sw_write(16'h0000);
        // R2 privilege violation, primary-secondary ctx 01
        ref_valid = 1; tte_hit = 1; tte_priv = 1; tte_writable = 1; tte_cacheable = 1;
        ref_cur_ctx = 2'b01;
        step();
        check("R8 first capture", 16'h0111);

        // R9 second fault: protection store, privileged, nucleus
        ref_valid = 1; tte_hit = 1; tte_cacheable = 1; ref_op = 2'd1; ref_priv = 1;
        ref_cur_ctx = 2'b10;
        step();
        check("R9 overrun with newer fields", 16'h082F);

        // R8 miss while valid: nothing changes
        ref_valid = 1; tte_hit = 0; ref_cur_ctx = 2'b00;
        step();
        check("R8 miss while valid keeps record", 16'h082F);

        // R11 capture beats a same-cycle clearing write
        ref_valid = 1; ref_bad_combo = 1; ref_asi_ctx = 2'b00; ref_cur_ctx = 2'b01;
        sw_we = 1; sw_wdata = 16'h0000;
        step();
        sw_we = 0;
        check("R11 capture wins over write", 16'h1003);

        sw_write(16'h0000);
        check("R11 clear", 16'h0000);

        // R8 miss while empty loads ctx only
        ref_valid = 1; tte_hit = 0; ref_cur_ctx = 2'b10;
        step();
        check("R8 miss loads context", 16'h0020);

        sw_write(16'hFFFF);
        check("R11 write all ones masked", 16'h3F3F);

        sw_write(16'h0000);
        // R8 invalid reference has no effect
        ref_valid = 0; tte_hit = 1; tte_priv = 1; ref_bad_combo = 1; ref_asi_invalid = 1;
        step();
        check("R8 ref_valid low ignored", 16'h0000);

        sw_write(16'h0105);
        check("R11 write loads held record", 16'h0105);

        // R9 fault on software-loaded record sets overrun
        ref_valid = 1; ref_asi_nontrans = 1; ref_op = 2'd2;
        step();
        check("R9 overrun after write", 16'h0437);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule